// File: doc/BRIEF.md
# GPIO bank with interrupt unit

A bank of 32 general-purpose pins behind a 32-bit register interface. Software controls the direction of each pin and its output latch. Every change goes through a pair of addresses: one where written ones set bits, and one where written ones clear bits. Bits written as zero keep their value, so no read-modify-write sequence is needed. Pin inputs pass through a two-flop synchroniser and can be read back at any time.

The eight lowest pins also have interrupt logic. A 32-bit control word holds four 8-bit fields:

- a rising/high enable
- a falling/low enable
- a debounce enable
- an edge-or-level select

In edge mode the enables pick which transitions are flagged. In level mode they pick the active level. The control word is changed only through its own set and clear addresses. Sticky status bits record events until software writes a one to clear them. Their OR drives a single interrupt line.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every register is zero. pin_oe and pin_out are 0, irq is 0, and all register reads return 0.
- R2: Writing ones to 0x04 sets direction bits and writing ones to 0x08 clears them. Bits written as zero are unchanged. Offset 0x00 reads the direction word, and pin_oe bit n = 1 makes pin n an output.
- R3: Writing ones to 0x10 sets output latch bits and writing ones to 0x14 clears them. Other bits are unchanged. Reading 0x10 returns the latch, which drives pin_out.
- R4: Offset 0x0C reads pin_in through a two-flop synchroniser. A change driven before clock edge k is visible after edge k+1, and not after edge k alone.
- R5: Writing ones to 0x18 sets interrupt-control bits and writing ones to 0x1C clears them. Reading 0x18 returns the control word. Its fields are:
  - bits 7:0: rise/high enable
  - bits 15:8: fall/low enable
  - bits 23:16: debounce enable
  - bits 31:24: level select (1 = level mode)
- R6: In edge mode, the rise bit flags rising edges and the fall bit flags falling edges. With both bits set, either edge is flagged. A transition whose enable is clear sets no status.
- R7: In level mode, the rise bit sets status while the input is high and the fall bit sets it while the input is low. Status stays set after the level goes away. A clear written while the level is still active leaves the bit set.
- R8: Offset 0x24 reads the status word. Writing a one to a bit of 0x20 clears only that status bit. Bits 31:8 always read 0, and pins 8 to 31 never produce status.
- R9: irq is 1 exactly when at least one status bit is set.
- R10: With debounce enabled, an input change reaches the detector only after it has differed from the filtered level at 4 consecutive sample ticks. A shorter pulse produces no status.
- R11: An event that occurs in the same cycle as a clear of the same status bit leaves the bit set.
- R12: Clearing a pin's rise and fall bits masks it: later activity sets no status, and the pin's level and debounce bits keep their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | 6 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, a combinational function of reg_addr |
| pin_in | input | 32 | Pin input levels, asynchronous to clk |
| pin_out | output | 32 | Output latch value |
| pin_oe | output | 32 | Per-pin output enable (1 = output) |
| irq | output | 1 | Combined interrupt request |

## Verification
A status bit can be set by a detected edge and cleared by a software write in the same cycle. The bench counts the register stages from the pin through the synchroniser, filter and edge compare. It then times a clear write to pin 6 so that it lands on the exact edge where the rising-edge event is presented. The check reads the status word afterwards and expects bit 6 still set, because the event must win over the clear. A separate plain clear then shows that the bit does clear when no event is present.

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int NPIN     = 32,
  parameter int NIRQ     = 8,
  parameter int AW       = 6,
  parameter int TICK_DIV = 16,
  parameter int DB_TICKS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [AW-1:0]   reg_addr,
  input  logic [NPIN-1:0] reg_wdata,
  output logic [NPIN-1:0] reg_rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  output logic            irq
);
  localparam int CTLW = 4 * NIRQ;
  localparam int TW   = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int CW   = (DB_TICKS > 1) ? $clog2(DB_TICKS) : 1;

  localparam logic [AW-1:0] A_DIR     = AW'(8'h00);
  localparam logic [AW-1:0] A_DIR_SET = AW'(8'h04);
  localparam logic [AW-1:0] A_DIR_CLR = AW'(8'h08);
  localparam logic [AW-1:0] A_VAL     = AW'(8'h0C);
  localparam logic [AW-1:0] A_OUT_SET = AW'(8'h10);
  localparam logic [AW-1:0] A_OUT_CLR = AW'(8'h14);
  localparam logic [AW-1:0] A_CTL_SET = AW'(8'h18);
  localparam logic [AW-1:0] A_CTL_CLR = AW'(8'h1C);
  localparam logic [AW-1:0] A_ST_CLR  = AW'(8'h20);
  localparam logic [AW-1:0] A_ST      = AW'(8'h24);

  logic [NPIN-1:0] dir_q, out_q, sync1, sync2;
  logic [CTLW-1:0] ctl_q;
  logic [NIRQ-1:0] st_q, filt, prev, evt, clr;
  logic [TW-1:0]   tick_cnt;
  logic            tick;

  wire [NIRQ-1:0] en_rise = ctl_q[NIRQ-1:0];
  wire [NIRQ-1:0] en_fall = ctl_q[2*NIRQ-1:NIRQ];
  wire [NIRQ-1:0] en_db   = ctl_q[3*NIRQ-1:2*NIRQ];
  wire [NIRQ-1:0] lvl     = ctl_q[4*NIRQ-1:3*NIRQ];

  wire wr_dir_set = reg_wr && reg_addr == A_DIR_SET;
  wire wr_dir_clr = reg_wr && reg_addr == A_DIR_CLR;
  wire wr_out_set = reg_wr && reg_addr == A_OUT_SET;
  wire wr_out_clr = reg_wr && reg_addr == A_OUT_CLR;
  wire wr_ctl_set = reg_wr && reg_addr == A_CTL_SET;
  wire wr_ctl_clr = reg_wr && reg_addr == A_CTL_CLR;
  wire wr_st_clr  = reg_wr && reg_addr == A_ST_CLR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
      ctl_q <= '0;
    end else begin
      if (wr_dir_set)      dir_q <= dir_q | reg_wdata;
      else if (wr_dir_clr) dir_q <= dir_q & ~reg_wdata;
      if (wr_out_set)      out_q <= out_q | reg_wdata;
      else if (wr_out_clr) out_q <= out_q & ~reg_wdata;
      if (wr_ctl_set)      ctl_q <= ctl_q | reg_wdata[CTLW-1:0];
      else if (wr_ctl_clr) ctl_q <= ctl_q & ~reg_wdata[CTLW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1    <= '0;
      sync2    <= '0;
      tick_cnt <= '0;
    end else begin
      sync1    <= pin_in;
      sync2    <= sync1;
      tick_cnt <= tick ? '0 : tick_cnt + 1'b1;
    end
  end
  assign tick = tick_cnt == TW'(TICK_DIV - 1);

  for (genvar i = 0; i < NIRQ; i++) begin : g_filt
    logic [CW-1:0] cnt;
    logic          f;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt <= '0;
        f   <= 1'b0;
      end else if (!en_db[i]) begin
        cnt <= '0;
        f   <= sync2[i];
      end else if (sync2[i] == f) begin
        cnt <= '0;
      end else if (tick) begin
        if (cnt == CW'(DB_TICKS - 1)) begin
          cnt <= '0;
          f   <= sync2[i];
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
    assign filt[i] = f;
  end

  assign evt = (~lvl & ((en_rise & filt & ~prev) | (en_fall & ~filt & prev)))
             | ( lvl & ((en_rise & filt) | (en_fall & ~filt)));
  assign clr = wr_st_clr ? reg_wdata[NIRQ-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= '0;
      st_q <= '0;
    end else begin
      prev <= filt;
      st_q <= (st_q & ~clr) | evt;
    end
  end

  always_comb begin
    case (reg_addr)
      A_DIR:                reg_rdata = dir_q;
      A_VAL:                reg_rdata = sync2;
      A_OUT_SET:            reg_rdata = out_q;
      A_CTL_SET, A_CTL_CLR: reg_rdata = NPIN'(ctl_q);
      A_ST:                 reg_rdata = NPIN'(st_q);
      default:              reg_rdata = '0;
    endcase
  end

  assign pin_oe  = dir_q;
  assign pin_out = out_q;
  assign irq     = |st_q;
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int NPIN = 32,
  parameter int NIRQ = 8,
  parameter int AW   = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr,
  input logic [AW-1:0]   reg_addr,
  input logic [NPIN-1:0] reg_wdata,
  input logic [NPIN-1:0] reg_rdata,
  input logic [NPIN-1:0] pin_out,
  input logic [NPIN-1:0] pin_oe,
  input logic            irq
);
  p_dir_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == AW'(8'h04) |=>
      ((pin_oe & $past(reg_wdata)) == $past(reg_wdata)) &&
      ((pin_oe & ~$past(reg_wdata)) == ($past(pin_oe) & ~$past(reg_wdata))));

  p_dir_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == AW'(8'h08) |=>
      ((pin_oe & $past(reg_wdata)) == '0) &&
      ((pin_oe & ~$past(reg_wdata)) == ($past(pin_oe) & ~$past(reg_wdata))));

  p_out_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == AW'(8'h10) |=>
      ((pin_out & $past(reg_wdata)) == $past(reg_wdata)) &&
      ((pin_out & ~$past(reg_wdata)) == ($past(pin_out) & ~$past(reg_wdata))));

  p_out_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == AW'(8'h14) |=>
      ((pin_out & $past(reg_wdata)) == '0) &&
      ((pin_out & ~$past(reg_wdata)) == ($past(pin_out) & ~$past(reg_wdata))));

  p_st_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == AW'(8'h24) |-> reg_rdata[NPIN-1:NIRQ] == '0);

  p_irq_or_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == AW'(8'h24) |-> irq == (|reg_rdata));

  p_out_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == AW'(8'h10) |-> reg_rdata == pin_out);
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPIN(NPIN), .NIRQ(NIRQ), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_out(pin_out),
  .pin_oe(pin_oe), .irq(irq)
);

// File: tb/gpio_irq_bank_test.sv
module gpio_irq_bank_test;
  logic        clk = 0, rst_n = 0, reg_wr = 0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, pin_in = '0;
  logic [31:0] reg_rdata, pin_out, pin_oe;
  logic        irq;
  int checks = 0, errors = 0;
  logic [31:0] d;

  always #5 clk = ~clk;

  gpio_irq_bank #(.TICK_DIV(4)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // {write addr, write data, read addr, expected read}
  localparam logic [75:0] VEC [7] = '{
    {6'h04, 32'h0000_00F0, 6'h00, 32'h0000_00F0},
    {6'h04, 32'h0000_0F00, 6'h00, 32'h0000_0FF0},
    {6'h08, 32'h0000_0030, 6'h00, 32'h0000_0FC0},
    {6'h10, 32'hA5A5_0000, 6'h10, 32'hA5A5_0000},
    {6'h14, 32'h0505_0000, 6'h10, 32'hA0A0_0000},
    {6'h18, 32'hFF00_00FF, 6'h18, 32'hFF00_00FF},
    {6'h1C, 32'hFF00_00FF, 6'h18, 32'h0000_0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] v);
    @(negedge clk);
    reg_addr = a; reg_wdata = v; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(6'h00, d); chk("R1 dir", d, 0);
    rd(6'h10, d); chk("R1 out", d, 0);
    rd(6'h18, d); chk("R1 ctl", d, 0);
    rd(6'h24, d); chk("R1 status", d, 0);
    chk("R1 pins", {pin_oe | pin_out, 31'b0, irq}, 0);
    rst_n = 1;

    // R2/R3/R5 register vectors
    for (int i = 0; i < 7; i++) begin
      wr(VEC[i][75:70], VEC[i][69:38]);
      rd(VEC[i][37:32], d);
      chk($sformatf("R2/R3/R5 vector %0d", i), d, VEC[i][31:0]);
    end
    chk("R2 pin_oe", pin_oe, 32'h0000_0FC0);
    chk("R3 pin_out", pin_out, 32'hA0A0_0000);

    // R4 synchroniser latency
    @(negedge clk); pin_in = 32'h1234_5600;
    @(negedge clk); rd(6'h0C, d); chk("R4 one edge", d, 0);
    @(negedge clk); rd(6'h0C, d); chk("R4 two edges", d, 32'h1234_5600);
    pin_in = 0; settle();

    // R6 edge mode, pin 0 rise only
    wr(6'h18, 32'h0000_0001);
    pin_in[0] = 1; settle();
    rd(6'h24, d); chk("R6 rise flagged", d, 32'h1);
    chk("R9 irq high", {31'b0, irq}, 1);
    wr(6'h20, 32'h1);
    rd(6'h24, d); chk("R8 clear", d, 0);
    chk("R9 irq low", {31'b0, irq}, 0);
    pin_in[0] = 0; settle();
    rd(6'h24, d); chk("R6 fall ignored", d, 0);

    // R6 both edges on pin 2
    wr(6'h18, 32'h0000_0404);
    pin_in[2] = 1; settle();
    rd(6'h24, d); chk("R6 both rise", d, 32'h4);
    wr(6'h20, 32'h4);
    pin_in[2] = 0; settle();
    rd(6'h24, d); chk("R6 both fall", d, 32'h4);
    pin_in[0] = 1; settle();
    rd(6'h24, d); chk("R8 two bits", d, 32'h5);
    wr(6'h20, 32'h1);
    rd(6'h24, d); chk("R8 selective clear", d, 32'h4);
    wr(6'h20, 32'hFF);

    // R8 upper pins never interrupt
    pin_in[9] = 1; pin_in[20] = 1; settle();
    pin_in[9] = 0; settle();
    rd(6'h24, d); chk("R8 upper pins", d, 0);

    // R7 level high on pin 3
    wr(6'h18, 32'h0800_0008); settle();
    rd(6'h24, d); chk("R7 inactive", d, 0);
    pin_in[3] = 1; settle();
    rd(6'h24, d); chk("R7 high active", d, 32'h8);
    wr(6'h20, 32'h8);
    rd(6'h24, d); chk("R7 clear while active", d, 32'h8);
    pin_in[3] = 0; settle();
    rd(6'h24, d); chk("R7 sticky", d, 32'h8);
    wr(6'h20, 32'h8);
    rd(6'h24, d); chk("R7 clear after", d, 0);

    // R7 level low on pin 4
    pin_in[4] = 1; settle();
    wr(6'h18, 32'h1000_1000); settle();
    rd(6'h24, d); chk("R7 low idle", d, 0);
    pin_in[4] = 0; settle();
    rd(6'h24, d); chk("R7 low active", d, 32'h10);
    pin_in[4] = 1; settle();
    wr(6'h20, 32'h10);
    rd(6'h24, d); chk("R7 low cleared", d, 0);

    // R12 mask pin 3 (give it debounce too)
    wr(6'h18, 32'h0008_0000);
    wr(6'h1C, 32'h0000_0808);
    rd(6'h18, d); chk("R12 mode kept", d, 32'h1808_1405);
    pin_in[3] = 1; settle();
    wr(6'h20, 32'hFF);
    rd(6'h24, d); chk("R12 masked", d, 0);

    // R10 debounce on pin 5 (rise + debounce)
    wr(6'h18, 32'h0020_0020);
    @(negedge clk); pin_in[5] = 1;
    repeat (3) @(negedge clk); pin_in[5] = 0;
    repeat (30) @(negedge clk);
    rd(6'h24, d); chk("R10 short pulse", d, 0);
    pin_in[5] = 1; settle();
    rd(6'h24, d); chk("R10 not yet", d, 0);
    repeat (34) @(negedge clk);
    rd(6'h24, d); chk("R10 stable", d, 32'h20);
    wr(6'h20, 32'h20);

    // R11 event coincident with clear on pin 6
    wr(6'h18, 32'h0000_0040);
    @(negedge clk); pin_in[6] = 1;
    repeat (3) @(negedge clk);
    reg_addr = 6'h20; reg_wdata = 32'h40; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
    rd(6'h24, d); chk("R11 event wins", d, 32'h40);
    wr(6'h20, 32'h40);
    rd(6'h24, d); chk("R11 later clear", d, 0);
    chk("R9 irq idle", {31'b0, irq}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule